// File: doc/BRIEF.md
# Width-Typed Integer ALU

This block is a 64-bit integer ALU in which every operation names its own data type: a lane size (byte, halfword, word or doubleword) and a signedness flag. The ALU first works out the plain bit result and then fits it to that type. The 64-bit output always holds a value that is properly sign- or zero-extended from the selected lane. No stale or garbage upper bits remain, so software never needs a separate extend instruction after an arithmetic step.

Operands are expected to arrive already extended to 64 bits, as a typed load or an earlier typed operation leaves them. Sources of mixed widths therefore combine correctly. The datapath is a single registered stage: a request presented with `in_valid` produces its result and `out_valid` on the next clock edge. When no request is presented, the output register keeps its value.

Top module: `typed_alu`

## Requirements
- R1: While `rst_n` is low and right after it, `out_valid` is 0 and `result` is all zeros.
- R2: `out_valid` equals the `in_valid` of the previous clock edge, and `result` takes the new value on that same edge.
- R3: A clock edge with `in_valid` low leaves `result` unchanged, whatever values the other inputs carry.
- R4: The `size` encoding is 00 for byte (8 bits), 01 for halfword (16), 10 for word (32) and 11 for doubleword (64). When `is_signed` is 1 and the size is narrower than 64 bits, every bit above the lane copies the lane's top bit. For example, a signed halfword add of 0x7FFF and 1 gives 0xFFFF_FFFF_FFFF_8000.
- R5: When `is_signed` is 0 and the size is narrower than 64 bits, every bit above the lane is zero. For example, an unsigned word add of 0xFFFF_FFFF and 1 gives 0.
- R6: Doubleword operations return the full 64-bit result, and the value of `is_signed` does not change it.
- R7: The opcodes 010 (AND), 011 (OR) and 100 (XOR) act bitwise and are then fitted to the type as in R4 and R5.
- R8: Opcode 101 shifts left. The shift amount is `src_b` modulo the lane width, and the result is fitted to the type.
- R9: Opcode 110 shifts right, using only the low lane bits of `src_a`. The shift is arithmetic when `is_signed` is 1 and logical when it is 0. The amount is `src_b` modulo the lane width.
- R10: Opcode 000 adds and opcode 001 subtracts (`src_a - src_b`). The unused opcode 111 yields a result of zero.
- R11: Operands that are already extended to 64 bits from different widths give the correct typed result. For example, a byte -3 plus a halfword 1000, computed as a signed halfword, gives 997.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| op | input | 3 | Operation code |
| size | input | 2 | Lane size of the operation |
| is_signed | input | 1 | 1 = signed type, 0 = unsigned type |
| src_a | input | 64 | First operand |
| src_b | input | 64 | Second operand or shift amount |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| result | output | 64 | Typed, extended result |

## Verification
Each result is due exactly one rising edge after its request, because a single register lies between the inputs and the outputs. The bench drives each request on a falling edge and lowers `in_valid` after one cycle. It then reads `result` and `out_valid` on the next falling edge, half a period after the capturing edge. To test the hold behaviour, the bench changes the inputs with `in_valid` low, waits one more falling edge, and confirms that the output did not move.

// File: rtl/typed_alu_pkg.sv
package typed_alu_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'b000,
        OP_SUB = 3'b001,
        OP_AND = 3'b010,
        OP_OR  = 3'b011,
        OP_XOR = 3'b100,
        OP_SHL = 3'b101,
        OP_SHR = 3'b110,
        OP_NUL = 3'b111
    } op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_DBL  = 2'b11
    } size_e;

    localparam int NUM_SIZES = 4;

endpackage

// File: rtl/typed_alu_extend.sv
// Fits a value to a lane: keeps the low lane bits and fills the rest with
// the lane's top bit (signed) or with zeros (unsigned).
module typed_alu_extend
    import typed_alu_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] din,
    input  logic [1:0]        size,
    input  logic              sgn,
    output logic [DATA_W-1:0] dout
);
    logic [DATA_W-1:0] cand [NUM_SIZES];

    for (genvar k = 0; k < NUM_SIZES; k++) begin : g_lane
        localparam int LANE_W = DATA_W >> (NUM_SIZES - 1 - k);
        if (LANE_W == DATA_W) begin : g_full
            assign cand[k] = din;
        end else begin : g_part
            assign cand[k] = {{(DATA_W - LANE_W){sgn & din[LANE_W-1]}},
                              din[LANE_W-1:0]};
        end
    end

    assign dout = cand[size];

endmodule

// File: rtl/typed_alu_shift.sv
// Lane-aware shifter: the amount wraps at the lane width; right shifts see
// an operand that has already been fitted to the lane.
module typed_alu_shift
    import typed_alu_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] a_raw,
    input  logic [DATA_W-1:0] a_fit,
    input  logic [DATA_W-1:0] b,
    input  logic [1:0]        size,
    input  logic              sgn,
    output logic [DATA_W-1:0] shl,
    output logic [DATA_W-1:0] shr
);
    localparam int SH_W = $clog2(DATA_W);

    logic [SH_W-1:0] amt;
    logic [SH_W-1:0] amt_mask;

    always_comb begin
        amt_mask = SH_W'((DATA_W >> (NUM_SIZES - 1 - int'(size))) - 1);
        amt      = b[SH_W-1:0] & amt_mask;
    end

    assign shl = a_raw << amt;
    assign shr = sgn ? DATA_W'($signed(a_fit) >>> amt) : (a_fit >> amt);

endmodule

// File: rtl/typed_alu_arith.sv
// Full-width add, subtract and bitwise logic; type fitting happens later.
module typed_alu_arith
    import typed_alu_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] sum,
    output logic [DATA_W-1:0] diff,
    output logic [DATA_W-1:0] band,
    output logic [DATA_W-1:0] bor,
    output logic [DATA_W-1:0] bxor
);
    assign sum  = a + b;
    assign diff = a - b;
    assign band = a & b;
    assign bor  = a | b;
    assign bxor = a ^ b;
endmodule

// File: rtl/typed_alu.sv
module typed_alu
    import typed_alu_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [2:0]        op,
    input  logic [1:0]        size,
    input  logic              is_signed,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    output logic              out_valid,
    output logic [DATA_W-1:0] result
);
    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } stage_t;

    stage_t st_d, st_q;

    logic [DATA_W-1:0] a_fit;
    logic [DATA_W-1:0] sum, diff, band, bor, bxor;
    logic [DATA_W-1:0] shl, shr;
    logic [DATA_W-1:0] raw;
    logic [DATA_W-1:0] typed;

    typed_alu_extend #(.DATA_W(DATA_W)) u_fit_a (
        .din (src_a),
        .size(size),
        .sgn (is_signed),
        .dout(a_fit)
    );

    typed_alu_arith #(.DATA_W(DATA_W)) u_arith (
        .a   (src_a),
        .b   (src_b),
        .sum (sum),
        .diff(diff),
        .band(band),
        .bor (bor),
        .bxor(bxor)
    );

    typed_alu_shift #(.DATA_W(DATA_W)) u_shift (
        .a_raw(src_a),
        .a_fit(a_fit),
        .b    (src_b),
        .size (size),
        .sgn  (is_signed),
        .shl  (shl),
        .shr  (shr)
    );

    always_comb begin
        case (op_e'(op))
            OP_ADD:  raw = sum;
            OP_SUB:  raw = diff;
            OP_AND:  raw = band;
            OP_OR:   raw = bor;
            OP_XOR:  raw = bxor;
            OP_SHL:  raw = shl;
            OP_SHR:  raw = shr;
            default: raw = '0;
        endcase
    end

    typed_alu_extend #(.DATA_W(DATA_W)) u_fit_out (
        .din (raw),
        .size(size),
        .sgn (is_signed),
        .dout(typed)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.data = typed;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign result    = st_q.data;

endmodule

// File: rtl/typed_alu_chk.sv
module typed_alu_chk #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [2:0]        op,
    input logic [1:0]        size,
    input logic              is_signed,
    input logic              out_valid,
    input logic [DATA_W-1:0] result
);
    // R2
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid));

    // R3
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result));

    // R4
    signed_byte_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(size) == 2'b00 && $past(is_signed))
            |-> (result[DATA_W-1:8] == {(DATA_W-8){result[7]}}));

    // R4
    signed_half_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(size) == 2'b01 && $past(is_signed))
            |-> (result[DATA_W-1:16] == {(DATA_W-16){result[15]}}));

    // R5
    unsigned_word_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(size) == 2'b10 && !$past(is_signed))
            |-> (result[DATA_W-1:32] == '0));

    // R10
    null_op_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(op) == 3'b111) |-> (result == '0));
endmodule

bind typed_alu typed_alu_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .op       (op),
    .size     (size),
    .is_signed(is_signed),
    .out_valid(out_valid),
    .result   (result)
);

// File: tb/typed_alu_bench.sv
`timescale 1ns/1ps
module typed_alu_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  op = '0;
    logic [1:0]  size = '0;
    logic        is_signed = 1'b0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic        out_valid;
    logic [63:0] result;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    typed_alu u_typed_alu (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .size(size),
        .is_signed(is_signed), .src_a(src_a), .src_b(src_b),
        .out_valid(out_valid), .result(result)
    );

    function automatic logic [63:0] fit(logic [63:0] v, int w, bit sg);
        logic [63:0] m;
        if (w == 64) return v;
        m = (64'd1 << w) - 64'd1;
        if (sg && v[w-1]) return (v & m) | ~m;
        return v & m;
    endfunction

    function automatic logic [63:0] model(logic [2:0] o, logic [1:0] sz, bit sg,
                                          logic [63:0] a, logic [63:0] b);
        int w;
        int amt;
        logic [63:0] r;
        logic [63:0] av;
        w   = 8 << sz;
        amt = int'(b[5:0]) % w;
        av  = fit(a, w, sg);
        case (o)
            3'd0: r = a + b;
            3'd1: r = a - b;
            3'd2: r = a & b;
            3'd3: r = a | b;
            3'd4: r = a ^ b;
            3'd5: r = a << amt;
            3'd6: r = sg ? 64'($signed(av) >>> amt) : (av >> amt);
            default: r = '0;
        endcase
        return fit(r, w, sg);
    endfunction

    task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic run(string tag, logic [2:0] o, logic [1:0] sz, bit sg,
                       logic [63:0] a, logic [63:0] b);
        logic [63:0] exp;
        exp = model(o, sz, sg, a, b);
        @(negedge clk);
        in_valid = 1'b1; op = o; size = sz; is_signed = sg; src_a = a; src_b = b;
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " R2 valid"}, {63'd0, out_valid}, 64'd1);
        check(tag, result, exp);
    endtask

    function automatic string tag_of(logic [2:0] o, logic [1:0] sz, bit sg);
        if (o == 3'd5) return "R8 rand";
        if (o == 3'd6) return "R9 rand";
        if (o >= 3'd2 && o <= 3'd4) return "R7 rand";
        if (o == 3'd7) return "R10 rand";
        if (sz == 2'b11) return "R6 rand";
        return sg ? "R4 rand" : "R5 rand";
    endfunction

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] held;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        // R1
        check("R1 reset valid", {63'd0, out_valid}, 64'd0);
        check("R1 reset result", result, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset valid", {63'd0, out_valid}, 64'd0);
        check("R1 after reset result", result, 64'd0);

        run("R4 signed half add", 3'd0, 2'b01, 1'b1, 64'h7FFF, 64'd1);
        check("R4 literal", result, 64'hFFFF_FFFF_FFFF_8000);
        run("R4 signed byte sub", 3'd1, 2'b00, 1'b1, 64'hFFFF_FFFF_FFFF_FF80, 64'd1);
        check("R4 literal sub", result, 64'h7F);
        run("R5 unsigned word add", 3'd0, 2'b10, 1'b0, 64'hFFFF_FFFF, 64'd1);
        check("R5 literal", result, 64'd0);
        run("R5 unsigned word top", 3'd0, 2'b10, 1'b0, 64'hFFFF_FFFE, 64'd1);
        check("R5 literal top", result, 64'hFFFF_FFFF);
        run("R6 dbl signed", 3'd0, 2'b11, 1'b1, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1);
        check("R6 literal s", result, 64'h8000_0000_0000_0000);
        run("R6 dbl unsigned", 3'd0, 2'b11, 1'b0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1);
        check("R6 literal u", result, 64'h8000_0000_0000_0000);
        run("R11 mixed widths", 3'd0, 2'b01, 1'b1, 64'hFFFF_FFFF_FFFF_FFFD, 64'd1000);
        check("R11 literal", result, 64'd997);
        run("R7 xor signed byte", 3'd4, 2'b00, 1'b1, 64'h0F, 64'hF0);
        check("R7 literal s", result, 64'hFFFF_FFFF_FFFF_FFFF);
        run("R7 xor unsigned byte", 3'd4, 2'b00, 1'b0, 64'h0F, 64'hF0);
        check("R7 literal u", result, 64'hFF);
        run("R8 shl wrap", 3'd5, 2'b00, 1'b0, 64'd1, 64'd9);
        check("R8 literal wrap", result, 64'd2);
        run("R8 shl into sign", 3'd5, 2'b00, 1'b1, 64'd1, 64'd7);
        check("R8 literal sign", result, 64'hFFFF_FFFF_FFFF_FF80);
        run("R9 sra half", 3'd6, 2'b01, 1'b1, 64'h8000, 64'd4);
        check("R9 literal sra", result, 64'hFFFF_FFFF_FFFF_F800);
        run("R9 srl half garbage", 3'd6, 2'b01, 1'b0, 64'hABCD_0000_0000_8000, 64'd4);
        check("R9 literal srl", result, 64'h0800);
        run("R10 null op", 3'd7, 2'b11, 1'b0, 64'h1234, 64'h5678);
        check("R10 literal", result, 64'd0);

        // R3: new inputs with in_valid low must not disturb the output
        run("R3 setup", 3'd3, 2'b10, 1'b0, 64'h1111_0000, 64'h0000_2222);
        held = result;
        op = 3'd0; src_a = 64'hDEAD; src_b = 64'hBEEF; size = 2'b11;
        @(negedge clk);
        check("R3 hold result", result, held);
        check("R3 hold valid", {63'd0, out_valid}, 64'd0);

        for (int i = 0; i < 400; i++) begin
            logic [2:0]  ro;
            logic [1:0]  rs;
            bit          rg;
            logic [63:0] ra, rb;
            ro = 3'($urandom_range(0, 7));
            rs = 2'($urandom_range(0, 3));
            rg = 1'($urandom_range(0, 1));
            ra = {$urandom, $urandom};
            rb = {$urandom, $urandom};
            if (i % 3 == 0) begin
                ra = fit(ra, 8 << $urandom_range(0, 3), 1'b1);
                rb = fit(rb, 8 << $urandom_range(0, 3), 1'b1);
            end
            run(tag_of(ro, rs, rg), ro, rs, rg, ra, rb);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule